// File: doc/BRIEF.md
# ALU Status Flag Generator

This block builds and holds the sixteen-bit processor status word that follows every arithmetic or logic step of an integer datapath. Each cycle the datapath may present its two operands, the result it produced, the carry or borrow it saw at the top of the operation width, a byte/word selector and an operation kind. The block derives carry, parity, auxiliary carry, zero, sign and overflow from these. The new values appear on the status word in the next cycle.

Three control flags share the same word: string direction, maskable-interrupt enable and single-step trap. A separate command port sets or clears each of them, one flag per command. A command and a condition update may arrive in the same cycle, and both take effect. Any bit the block does not define reads as zero.

Top module: `statusWordUnit`

## Requirements
- R1: After reset all sixteen bits of `flagWord` are 0. Bits 1, 3, 5, 12, 13, 14 and 15 always read 0.
- R2: Carry (bit 0) takes the value of `carryOut` after an add (`opKind`=0) or a subtract (`opKind`=1). For a subtract, `carryOut` carries the borrow into the top bit.
- R3: Parity (bit 2) is 1 when bits 7..0 of `opRes` hold an even number of ones, for byte and word operations alike. It is updated by add, subtract and logic operations.
- R4: After an add or a subtract, auxiliary carry (bit 4) equals bit 4 of `opA ^ opB ^ opRes`, which is the carry out of or borrow into bit 3.
- R5: Zero (bit 6) is 1 exactly when the result within the operation width is zero. Sign (bit 7) equals the top bit of that width: bit 15 when `isWord`=1, bit 7 when `isWord`=0.
- R6: Overflow (bit 11) is set after an add when both operands have the same sign and the result has a different sign. It is set after a subtract when the operands differ in sign and the result sign differs from `opA`. Otherwise it is 0.
- R7: A logic operation (`opKind`=2) clears carry and overflow, leaves auxiliary carry unchanged, and updates parity, zero and sign.
- R8: When `opValid`=0, or when `opKind`=3, the six condition flags keep their values.
- R9: When `ctlValid`=1, the flag chosen by `ctlSel` (0 = direction, bit 10; 1 = interrupt enable, bit 9; 2 = trap, bit 8) takes the value of `ctlVal`. `ctlSel`=3 changes nothing. Condition updates never change these bits, and commands never change condition bits.
- R10: Every update shows on `flagWord` in the first cycle after the clock edge that samples the request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| opValid | input | 1 | Condition-flag update request |
| opKind | input | 2 | 0 add, 1 subtract, 2 logic, 3 no flag change |
| isWord | input | 1 | 1 word width, 0 byte width |
| opA | input | 16 | First operand |
| opB | input | 16 | Second operand |
| opRes | input | 16 | Result from the datapath |
| carryOut | input | 1 | Carry (add) or borrow (subtract) at the width's top bit |
| ctlValid | input | 1 | Control-flag command request |
| ctlSel | input | 2 | Selects the control flag |
| ctlVal | input | 1 | Value written to the selected control flag |
| flagWord | output | 16 | Status word |

## Verification
The hardest case to reach is a logic operation that arrives while auxiliary carry is already 1. It has to show that the bit is held rather than recomputed from operands whose bit-4 parity would give 0. The stimulus first runs an add whose bit-4 operand and result bits give a 1. It then issues a logic operation with operands that would produce 0, and checks that the bit stays set. Byte operations with a nonzero upper byte and a zero low byte are also driven. They show that zero and sign ignore the upper byte while parity looks only at the low byte. Long random runs mix commands with condition updates in the same cycle, so that writes to both parts of the word collide.

// File: rtl/status_pkg.sv
package status_pkg;

  localparam int FLAG_W = 16;
  localparam int BYTE_W = 8;

  localparam int POS_C = 0;
  localparam int POS_P = 2;
  localparam int POS_A = 4;
  localparam int POS_Z = 6;
  localparam int POS_S = 7;
  localparam int POS_T = 8;
  localparam int POS_I = 9;
  localparam int POS_D = 10;
  localparam int POS_O = 11;

  localparam int NUM_CTL = 3;

  typedef enum logic [1:0] {
    KIND_ADD   = 2'd0,
    KIND_SUB   = 2'd1,
    KIND_LOGIC = 2'd2,
    KIND_NONE  = 2'd3
  } opKind_e;

  typedef struct packed {
    logic               condEn;
    logic               isAdd;
    logic               isSub;
    logic               isLogic;
    logic               wordOp;
    logic [NUM_CTL-1:0] ctlWr;
    logic               ctlVal;
  } flagStrobe_t;

  function automatic int ctlPos(input int idx);
    case (idx)
      0:       return POS_D;
      1:       return POS_I;
      default: return POS_T;
    endcase
  endfunction

endpackage

// File: rtl/flag_ctrl.sv
module flagCtrl
  import status_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        opValid,
  input  logic [1:0]  opKind,
  input  logic        isWord,
  input  logic        ctlValid,
  input  logic [1:0]  ctlSel,
  input  logic        ctlVal,
  output flagStrobe_t strobe
);

  opKind_e kindDec;
  logic    kindLive;
  logic [NUM_CTL-1:0] ctlWrDec;

  assign kindDec  = opKind_e'(opKind);
  assign kindLive = opValid && (kindDec != KIND_NONE);

  for (genvar gi = 0; gi < NUM_CTL; gi++) begin : g_ctlDec
    assign ctlWrDec[gi] = ctlValid && (ctlSel == 2'(gi));
  end

  always_comb begin
    strobe         = '0;
    strobe.condEn  = kindLive;
    strobe.isAdd   = kindLive && (kindDec == KIND_ADD);
    strobe.isSub   = kindLive && (kindDec == KIND_SUB);
    strobe.isLogic = kindLive && (kindDec == KIND_LOGIC);
    strobe.wordOp  = isWord;
    strobe.ctlWr   = ctlWrDec;
    strobe.ctlVal  = ctlVal;
  end

  AST_ONE_KIND: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strobe.isAdd, strobe.isSub, strobe.isLogic})) else $error("kind strobes overlap"); // R8

  AST_CTL_ONEHOT: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(strobe.ctlWr)) else $error("more than one control write"); // R9

endmodule

// File: rtl/flag_path.sv
module flagPath
  import status_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  flagStrobe_t       strobe,
  input  logic [DATA_W-1:0] opA,
  input  logic [DATA_W-1:0] opB,
  input  logic [DATA_W-1:0] opRes,
  input  logic              carryOut,
  output logic [FLAG_W-1:0] flagWord
);

  localparam int TOP_W  = DATA_W - 1;
  localparam int TOP_B  = BYTE_W - 1;
  localparam int AUX_B  = 4;

  logic [FLAG_W-1:0] flagReg;
  logic signA, signB, signR;
  logic resZero, resParity, auxBit, ovfAdd, ovfSub;
  logic nextC, nextA, nextO;

  assign signA = strobe.wordOp ? opA[TOP_W]   : opA[TOP_B];
  assign signB = strobe.wordOp ? opB[TOP_W]   : opB[TOP_B];
  assign signR = strobe.wordOp ? opRes[TOP_W] : opRes[TOP_B];

  assign resZero   = strobe.wordOp ? (opRes == '0) : (opRes[TOP_B:0] == '0);
  assign resParity = ~^opRes[TOP_B:0];
  assign auxBit    = opA[AUX_B] ^ opB[AUX_B] ^ opRes[AUX_B];
  assign ovfAdd    = (signA == signB) && (signR != signA);
  assign ovfSub    = (signA != signB) && (signR != signA);

  always_comb begin
    nextC = flagReg[POS_C];
    nextA = flagReg[POS_A];
    nextO = flagReg[POS_O];
    if (strobe.isAdd) begin
      nextC = carryOut;
      nextA = auxBit;
      nextO = ovfAdd;
    end else if (strobe.isSub) begin
      nextC = carryOut;
      nextA = auxBit;
      nextO = ovfSub;
    end else if (strobe.isLogic) begin
      nextC = 1'b0;
      nextO = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      flagReg <= '0;
    end else begin
      if (strobe.condEn) begin
        flagReg[POS_C] <= nextC;
        flagReg[POS_P] <= resParity;
        flagReg[POS_A] <= nextA;
        flagReg[POS_Z] <= resZero;
        flagReg[POS_S] <= signR;
        flagReg[POS_O] <= nextO;
      end
      for (int k = 0; k < NUM_CTL; k++) begin
        if (strobe.ctlWr[k]) flagReg[ctlPos(k)] <= strobe.ctlVal;
      end
    end
  end

  assign flagWord = flagReg;

  AST_LOGIC_CLEARS: assert property (@(posedge clk) disable iff (!rstN)
    strobe.isLogic |=> (!flagWord[POS_C] && !flagWord[POS_O])) else $error("logic left C/O"); // R7

  AST_LOGIC_KEEPS_AUX: assert property (@(posedge clk) disable iff (!rstN)
    strobe.isLogic |=> (flagWord[POS_A] == $past(flagWord[POS_A]))) else $error("logic touched A"); // R7

  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.condEn |=> ({flagWord[POS_O], flagWord[POS_S], flagWord[POS_Z], flagWord[POS_A], flagWord[POS_P], flagWord[POS_C]}
      == $past({flagWord[POS_O], flagWord[POS_S], flagWord[POS_Z], flagWord[POS_A], flagWord[POS_P], flagWord[POS_C]})))
    else $error("condition flags moved while idle"); // R8

  AST_CTL_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.ctlWr == '0) |=> $stable(flagWord[POS_D:POS_T])) else $error("control flags moved"); // R9

  AST_ZERO_NOT_NEG: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.condEn && resZero) |=> !flagWord[POS_S]) else $error("zero result with sign set"); // R5

endmodule

// File: rtl/status_word_unit.sv
module statusWordUnit
  import status_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              opValid,
  input  logic [1:0]        opKind,
  input  logic              isWord,
  input  logic [DATA_W-1:0] opA,
  input  logic [DATA_W-1:0] opB,
  input  logic [DATA_W-1:0] opRes,
  input  logic              carryOut,
  input  logic              ctlValid,
  input  logic [1:0]        ctlSel,
  input  logic              ctlVal,
  output logic [FLAG_W-1:0] flagWord
);

  flagStrobe_t strobe;

  flagCtrl u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .opValid  (opValid),
    .opKind   (opKind),
    .isWord   (isWord),
    .ctlValid (ctlValid),
    .ctlSel   (ctlSel),
    .ctlVal   (ctlVal),
    .strobe   (strobe)
  );

  flagPath #(.DATA_W(DATA_W)) u_path (
    .clk      (clk),
    .rstN     (rstN),
    .strobe   (strobe),
    .opA      (opA),
    .opB      (opB),
    .opRes    (opRes),
    .carryOut (carryOut),
    .flagWord (flagWord)
  );

endmodule

// File: tb/tb_statusWordUnit.sv
module tb_statusWordUnit;

  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        opValid = 1'b0;
  logic [1:0]  opKind = 2'd0;
  logic        isWord = 1'b0;
  logic [15:0] opA = '0, opB = '0, opRes = '0;
  logic        carryOut = 1'b0;
  logic        ctlValid = 1'b0;
  logic [1:0]  ctlSel = 2'd3;
  logic        ctlVal = 1'b0;
  logic [15:0] flagWord;

  int nCmp = 0;
  int nBad = 0;
  bit started = 0;
  string phase = "R1 reset";
  logic [15:0] model = '0;

  always #(CLK_PERIOD/2) clk = ~clk;

  statusWordUnit dut (
    .clk(clk), .rstN(rstN), .opValid(opValid), .opKind(opKind), .isWord(isWord),
    .opA(opA), .opB(opB), .opRes(opRes), .carryOut(carryOut),
    .ctlValid(ctlValid), .ctlSel(ctlSel), .ctlVal(ctlVal), .flagWord(flagWord)
  );

  // Behavioural reference: next status word from the current request (R10: one edge of latency)
  always @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      model <= '0;
    end else begin
      logic [15:0] nx;
      int w, ones;
      logic sa, sb, sr;
      logic [15:0] msk;
      nx = model;
      w = isWord ? 16 : 8;
      msk = isWord ? 16'hFFFF : 16'h00FF;
      sa = opA[w-1]; sb = opB[w-1]; sr = opRes[w-1];
      ones = 0;
      for (int i = 0; i < 8; i++) ones += int'(opRes[i]);
      if (opValid && opKind != 2'd3) begin
        nx[2] = (ones % 2) == 0;
        nx[6] = (opRes & msk) == 0;
        nx[7] = sr;
        if (opKind == 2'd2) begin
          nx[0] = 0; nx[11] = 0;
        end else begin
          nx[0] = carryOut;
          nx[4] = opA[4] ^ opB[4] ^ opRes[4];
          if (opKind == 2'd0) nx[11] = (sa == sb) && (sr != sa);
          else                nx[11] = (sa != sb) && (sr != sa);
        end
      end
      if (ctlValid) begin
        case (ctlSel)
          2'd0: nx[10] = ctlVal;
          2'd1: nx[9]  = ctlVal;
          2'd2: nx[8]  = ctlVal;
          default: ;
        endcase
      end
      model <= nx;
    end
  end

  task automatic checkBit(input int pos, input string req);
    nCmp++;
    if (flagWord[pos] !== model[pos]) begin
      nBad++;
      $display("FAIL %s bit %0d (%s): actual %b expected %b", req, pos, phase, flagWord[pos], model[pos]);
    end
  endtask

  always @(negedge clk) begin
    if (started) begin
      checkBit(0, "R2");  checkBit(2, "R3");  checkBit(4, "R4");
      checkBit(6, "R5");  checkBit(7, "R5");  checkBit(11, "R6");
      checkBit(8, "R9");  checkBit(9, "R9");  checkBit(10, "R9");
      nCmp++;
      if ((flagWord & 16'hF02A) !== 16'h0000) begin
        nBad++;
        $display("FAIL R1 unused bits (%s): actual %h expected 0000", phase, flagWord & 16'hF02A);
      end
    end
  end

  task automatic op(input logic [1:0] k, input logic w, input logic [15:0] a, input logic [15:0] b,
                    input logic [15:0] r, input logic c);
    opValid = 1; opKind = k; isWord = w; opA = a; opB = b; opRes = r; carryOut = c;
    @(negedge clk);
    opValid = 0;
  endtask

  task automatic ctl(input logic [1:0] s, input logic v);
    ctlValid = 1; ctlSel = s; ctlVal = v;
    @(negedge clk);
    ctlValid = 0;
  endtask

  task automatic finishRun();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nCmp, nBad);
    $finish;
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    nBad++;
    $display("FAIL watchdog: actual timeout expected completion");
    finishRun();
  end

  initial begin
    repeat (3) @(negedge clk);
    started = 1;
    nCmp++;
    if (flagWord !== 16'h0000) begin
      nBad++;
      $display("FAIL R1 reset word: actual %h expected 0000", flagWord);
    end
    rstN = 1;
    @(negedge clk);
    phase = "R2 R6 word add overflow";
    op(2'd0, 1, 16'h7FFF, 16'h0001, 16'h8000, 0);
    phase = "R2 word add carry zero";
    op(2'd0, 1, 16'hFFFF, 16'h0001, 16'h0000, 1);
    phase = "R6 sub overflow";
    op(2'd1, 1, 16'h8000, 16'h0001, 16'h7FFF, 0);
    phase = "R5 R3 byte upper ignored";
    op(2'd0, 0, 16'h1280, 16'h3480, 16'h4600, 1);
    phase = "R4 aux then R7 logic keeps it";
    op(2'd0, 0, 16'h0008, 16'h0008, 16'h0010, 0);
    op(2'd2, 1, 16'h8001, 16'h0001, 16'h8001, 1);
    phase = "R8 kind none";
    op(2'd3, 1, 16'h0000, 16'h0000, 16'h0000, 1);
    phase = "R8 idle";
    repeat (2) @(negedge clk);
    phase = "R9 control set";
    ctl(2'd0, 1); ctl(2'd1, 1); ctl(2'd2, 1);
    phase = "R9 sel none";
    ctl(2'd3, 0);
    phase = "R9 collide with op";
    ctlValid = 1; ctlSel = 2'd1; ctlVal = 0;
    op(2'd1, 0, 16'h0000, 16'h0001, 16'h00FF, 1);
    ctlValid = 0;
    phase = "R10 random mix";
    for (int n = 0; n < 4000; n++) begin
      opValid  = $urandom_range(0, 3) != 0;
      opKind   = 2'($urandom_range(0, 3));
      isWord   = 1'($urandom_range(0, 1));
      opA      = 16'($urandom);
      opB      = 16'($urandom);
      opRes    = ($urandom_range(0, 7) == 0) ? 16'h0000 : 16'($urandom);
      carryOut = 1'($urandom_range(0, 1));
      ctlValid = 1'($urandom_range(0, 1));
      ctlSel   = 2'($urandom_range(0, 3));
      ctlVal   = 1'($urandom_range(0, 1));
      @(negedge clk);
    end
    opValid = 0; ctlValid = 0;
    @(negedge clk);
    finishRun();
  end

endmodule